// File: doc/BRIEF.md
# Speculative Load-Store Queue

This block is a small queue that sits beside one out-of-order core. It holds memory operations in program order and lets loads go to memory early. The core allocates an entry for each memory instruction and gives it an op type, a tag and an immediate offset. A rename/issue model then sends two kinds of events, each naming a queue index. One kind delivers the base operand of an entry's address. The other delivers the data of a store. The queue adds offset and base, sends loads to a single-ported data memory, and keeps stores until the core commits them.

Loads are issued on the guess that they do not depend on any older store whose address is still unknown. When an older store's address resolves later and matches a younger load that has already read memory, the queue marks that load, replays it, and raises a violation pulse carrying the load's index. A dependence predictor or flush controller can watch that pulse. The data memory port is shared, and one access is granted per cycle: store commit first, then replays, then the oldest load that is ready.

Top module: `lsq_spec_queue`

## Requirements
- R1: Entries are allocated at the tail of an 8-entry circular queue, and `alloc_idx` gives the index the next allocation receives. When all 8 entries are held, `alloc_ready` is low and an allocation request is ignored.
- R2: An entry's effective address is the 16-bit sum, wrapping, of its allocation offset and the base delivered by an operand event. The address is formed in the cycle after the event. With no competing access, a load presented with its base in cycle c therefore reaches memory in cycle c+2.
- R3: A load goes to memory (`mem_en`=1, `mem_wr`=0) in the cycle after its address is formed. It does not wait for older stores whose addresses are unknown. `ld_resp_*` reports the load's index, tag and value in that same cycle.
- R4: A store writes memory only in the cycle its commit is accepted. Commit is accepted when `commit_valid` and `commit_ready` are both high, and `commit_ready` means the oldest entry is complete. Writes go out in program order, with the store's address and data.
- R5: When an older store's address forms and equals the address of a younger load that has already accessed memory, that load accesses memory again in the next cycle in which the store's data is valid. The earliest such cycle is the cycle after the store's address forms. `viol_valid` pulses in that access with `viol_idx` equal to the load's index.
- R6: A load whose address differs from every older store address is never replayed.
- R7: A replayed load returns the data of the youngest older store with a matching full 16-bit address.
- R8: At most one memory access occurs per cycle. Store commit wins over a replay, and a replay wins over a first issue. Among loads of the same kind, the oldest is served first.
- R9: After a synchronous active-low reset the queue is empty: `alloc_ready`=1, `commit_ready`=0, `mem_en`=0, `ld_resp_valid`=0, `viol_valid`=0.
- R10: When a load first issues after an older store's matching address is already known, it takes that store's data. If that data is not yet valid, the load waits for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_tag | input | 6 | Instruction tag |
| alloc_offset | input | 16 | Address offset |
| alloc_ready | output | 1 | A free entry exists |
| alloc_idx | output | 3 | Index the next allocation takes |
| opnd_valid | input | 1 | Base operand event |
| opnd_idx | input | 3 | Entry receiving the base |
| opnd_base | input | 16 | Base value |
| sdat_valid | input | 1 | Store data event |
| sdat_idx | input | 3 | Store entry receiving data |
| sdat_value | input | 32 | Store data |
| commit_valid | input | 1 | Request to retire the oldest entry |
| commit_ready | output | 1 | Oldest entry complete |
| mem_en | output | 1 | Memory access this cycle |
| mem_wr | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, same cycle |
| ld_resp_valid | output | 1 | Load value produced |
| ld_resp_idx | output | 3 | Load entry |
| ld_resp_tag | output | 6 | Load tag |
| ld_resp_data | output | 32 | Load value |
| viol_valid | output | 1 | Ordering violation replay |
| viol_idx | output | 3 | Replayed load entry |

## Verification
Some properties are checked on every cycle. There is never a write and a load response in the same cycle. A write never appears without a commit request. Every memory access is either a write or a load response. An address bit only rises after the entry spent a cycle with its operand pending. A blocked allocation never grows the occupancy. Only the bench scenarios can show the rest. These are the cycle-exact issue timing, the replay that waits for late store data, which of several matching stores supplies the value, the absence of replays for disjoint addresses, and the point at which memory actually changes.

// File: rtl/lsq_pkg.sv
// Package: shared constants and types for the speculative load-store queue.
// Assumes a power-of-two queue depth so indices wrap naturally.
package lsq_pkg;
    localparam int LSQ_DEPTH  = 8;
    localparam int LSQ_ADDR_W = 16;
    localparam int LSQ_DATA_W = 32;
    localparam int LSQ_TAG_W  = 6;

    // Kind of access granted on the memory port in a cycle
    typedef enum logic [1:0] {
        GNT_NONE   = 2'd0,
        GNT_COMMIT = 2'd1,
        GNT_REPLAY = 2'd2,
        GNT_ISSUE  = 2'd3
    } gnt_kind_e;
endpackage

// File: rtl/lsq_age_pick.sv
// Module: picks the oldest requesting entry of a circular queue.
// Assumes DEPTH is a power of two; age is counted from head.
module lsq_age_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from youngest to oldest so the oldest request is written last
    always_comb begin
        found = 1'b0;
        idx   = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            logic [IDX_W-1:0] j;
            j = head + IDX_W'(k);
            if (req[j]) begin
                found = 1'b1;
                idx   = j;
            end
        end
    end
endmodule

// File: rtl/lsq_fwd_search.sv
// Module: finds the youngest store older than a given load whose known
// address equals the load's address. Assumes power-of-two DEPTH.
module lsq_fwd_search #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [IDX_W-1:0]  head,
    input  logic [DEPTH-1:0]  st_known,
    input  logic [ADDR_W-1:0] addr_q [DEPTH],
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [IDX_W-1:0] ld_age;

    assign ld_age = ld_idx - head;

    // Walk older entries far to near; nearest match is written last
    always_comb begin
        hit     = 1'b0;
        hit_idx = ld_idx;
        for (int k = DEPTH - 1; k >= 1; k--) begin
            logic [IDX_W-1:0] j;
            j = ld_idx - IDX_W'(k);
            if (IDX_W'(k) <= ld_age && st_known[j] && addr_q[j] == addr_q[ld_idx]) begin
                hit     = 1'b1;
                hit_idx = j;
            end
        end
    end
endmodule

// File: rtl/lsq_spec_queue.sv
// Module: speculative load-store queue. Allocates in program order, forms
// addresses, issues loads past unresolved stores, detects ordering
// violations and replays, and writes stores at commit.
// Assumes events only name allocated entries and never arrive in the
// same cycle as that entry's allocation.
module lsq_spec_queue
    import lsq_pkg::*;
#(
    parameter int DEPTH  = LSQ_DEPTH,
    parameter int ADDR_W = LSQ_ADDR_W,
    parameter int DATA_W = LSQ_DATA_W,
    parameter int TAG_W  = LSQ_TAG_W,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_offset,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              opnd_valid,
    input  logic [IDX_W-1:0]  opnd_idx,
    input  logic [ADDR_W-1:0] opnd_base,
    input  logic              sdat_valid,
    input  logic [IDX_W-1:0]  sdat_idx,
    input  logic [DATA_W-1:0] sdat_value,
    input  logic              commit_valid,
    output logic              commit_ready,
    output logic              mem_en,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_resp_valid,
    output logic [IDX_W-1:0]  ld_resp_idx,
    output logic [TAG_W-1:0]  ld_resp_tag,
    output logic [DATA_W-1:0] ld_resp_data,
    output logic              viol_valid,
    output logic [IDX_W-1:0]  viol_idx
);
    // Entry state
    logic [DEPTH-1:0]  valid_q, is_st_q, pend_q, addr_v_q, data_v_q, issued_q, replay_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [ADDR_W-1:0] off_q  [DEPTH];
    logic [ADDR_W-1:0] base_q [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [IDX_W-1:0]  head_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [IDX_W-1:0]  tail;
    logic              alloc_fire, head_done, commit_fire, st_commit;
    logic [DEPTH-1:0]  st_known, fwd_hit, fwd_ok, rep_req, iss_req, viol_set;
    logic [IDX_W-1:0]  fwd_idx [DEPTH];
    logic [IDX_W-1:0]  age     [DEPTH];
    logic [ADDR_W-1:0] new_addr[DEPTH];
    logic              rep_found, iss_found, ld_grant;
    logic [IDX_W-1:0]  rep_idx, iss_idx, ld_sel;
    gnt_kind_e         gnt;

    assign tail        = head_q + cnt_q[IDX_W-1:0];
    assign alloc_ready = (cnt_q != CNT_W'(DEPTH));
    assign alloc_idx   = tail;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign head_done   = is_st_q[head_q] ? (addr_v_q[head_q] && data_v_q[head_q])
                                         : (issued_q[head_q] && !replay_q[head_q]);
    assign commit_ready = (cnt_q != '0) && head_done;
    assign commit_fire  = commit_valid && commit_ready;
    assign st_commit    = commit_fire && is_st_q[head_q];
    assign st_known     = valid_q & is_st_q & addr_v_q;

    // Per-entry forwarding search, age and next address
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        lsq_fwd_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fwd (
            .ld_idx   (IDX_W'(g)),
            .head     (head_q),
            .st_known (st_known),
            .addr_q   (addr_q),
            .hit      (fwd_hit[g]),
            .hit_idx  (fwd_idx[g])
        );
        assign fwd_ok[g]   = !fwd_hit[g] || data_v_q[fwd_idx[g]];
        assign rep_req[g]  = valid_q[g] && !is_st_q[g] && replay_q[g] && fwd_ok[g];
        assign iss_req[g]  = valid_q[g] && !is_st_q[g] && addr_v_q[g] && !issued_q[g] && fwd_ok[g];
        assign age[g]      = IDX_W'(g) - head_q;
        assign new_addr[g] = base_q[g] + off_q[g];
    end

    lsq_age_pick #(.DEPTH(DEPTH)) u_pick_rep (
        .req(rep_req), .head(head_q), .found(rep_found), .idx(rep_idx));
    lsq_age_pick #(.DEPTH(DEPTH)) u_pick_iss (
        .req(iss_req), .head(head_q), .found(iss_found), .idx(iss_idx));

    // Arbitrate the single memory port: commit, then replay, then issue
    always_comb begin
        if (st_commit)      gnt = GNT_COMMIT;
        else if (rep_found) gnt = GNT_REPLAY;
        else if (iss_found) gnt = GNT_ISSUE;
        else                gnt = GNT_NONE;
    end

    assign ld_grant = (gnt == GNT_REPLAY) || (gnt == GNT_ISSUE);
    assign ld_sel   = (gnt == GNT_REPLAY) ? rep_idx : iss_idx;

    assign mem_en        = (gnt != GNT_NONE);
    assign mem_wr        = (gnt == GNT_COMMIT);
    assign mem_addr      = mem_wr ? addr_q[head_q] : addr_q[ld_sel];
    assign mem_wdata     = data_q[head_q];
    assign ld_resp_valid = ld_grant;
    assign ld_resp_idx   = ld_sel;
    assign ld_resp_tag   = tag_q[ld_sel];
    assign ld_resp_data  = fwd_hit[ld_sel] ? data_q[fwd_idx[ld_sel]] : mem_rdata;
    assign viol_valid    = (gnt == GNT_REPLAY);
    assign viol_idx      = ld_sel;

    // Flag younger accessed loads hit by a store address forming this cycle
    always_comb begin
        viol_set = '0;
        for (int l = 0; l < DEPTH; l++) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (valid_q[l] && !is_st_q[l] && addr_v_q[l]
                    && (issued_q[l] || (ld_grant && ld_sel == IDX_W'(l)))
                    && valid_q[s] && is_st_q[s] && pend_q[s]
                    && age[s] < age[l] && new_addr[s] == addr_q[l])
                    viol_set[l] = 1'b1;
            end
        end
    end

    // Control state: occupancy, pointers and per-entry flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            is_st_q  <= '0;
            pend_q   <= '0;
            addr_v_q <= '0;
            data_v_q <= '0;
            issued_q <= '0;
            replay_q <= '0;
            head_q   <= '0;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
            if (commit_fire) begin
                valid_q[head_q] <= 1'b0;
                head_q          <= head_q + 1'b1;
            end
            if (alloc_fire) begin
                valid_q[tail]  <= 1'b1;
                is_st_q[tail]  <= alloc_is_store;
                pend_q[tail]   <= 1'b0;
                addr_v_q[tail] <= 1'b0;
                data_v_q[tail] <= 1'b0;
                issued_q[tail] <= 1'b0;
                replay_q[tail] <= 1'b0;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (pend_q[i]) begin
                    pend_q[i]   <= 1'b0;
                    addr_v_q[i] <= 1'b1;
                end
            end
            if (opnd_valid) pend_q[opnd_idx]   <= 1'b1;
            if (sdat_valid) data_v_q[sdat_idx] <= 1'b1;
            if (ld_grant) begin
                issued_q[ld_sel] <= 1'b1;
                replay_q[ld_sel] <= 1'b0;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (viol_set[i]) replay_q[i] <= 1'b1;
            end
        end
    end

    // Datapath state: tags, offsets, bases, addresses and store data
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            tag_q[tail] <= alloc_tag;
            off_q[tail] <= alloc_offset;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (pend_q[i]) addr_q[i] <= new_addr[i];
        end
        if (opnd_valid) base_q[opnd_idx] <= opnd_base;
        if (sdat_valid) data_q[sdat_idx] <= sdat_value;
    end

    // R1: a refused allocation never grows the occupancy
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_ready) |=> (cnt_q <= $past(cnt_q)));

    // R4: memory is written only under a commit request
    a_r4_write_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> commit_valid);

    // R8: a store write and a load response never share a cycle
    a_r8_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !ld_resp_valid);

    // R3: every memory access is either a write or a load response
    a_r3_access_kind: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_wr || ld_resp_valid));

    // R2: an address becomes valid only after a pending cycle
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        a_r2_addr_after_event: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(addr_v_q[g]) |-> $past(pend_q[g]));
    end
endmodule

// File: tb/lsq_spec_queue_tb.sv
`timescale 1ns/1ps
module lsq_spec_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, alloc_is_store = 1'b0;
    logic [5:0]  alloc_tag = '0;
    logic [15:0] alloc_offset = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_idx;
    logic        opnd_valid = 1'b0;
    logic [2:0]  opnd_idx = '0;
    logic [15:0] opnd_base = '0;
    logic        sdat_valid = 1'b0;
    logic [2:0]  sdat_idx = '0;
    logic [31:0] sdat_value = '0;
    logic        commit_valid = 1'b0, commit_ready;
    logic        mem_en, mem_wr;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        ld_resp_valid, viol_valid;
    logic [2:0]  ld_resp_idx, viol_idx;
    logic [5:0]  ld_resp_tag;
    logic [31:0] ld_resp_data;

    lsq_spec_queue u_dut (.*);

    always #2 clk = ~clk;

    logic [31:0] mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_en && mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    int vec = 0, mis = 0, cycno = 0;
    // Behavioural reference model state
    int m_head = 0, m_cnt = 0;
    bit mv[8], mst[8], mpend[8], mav[8], mdv[8], miss[8], mrep[8];
    int mtag[8], moff[8], mbase[8], maddr[8], mdata[8], mm[256];
    // Decisions of the current cycle
    bit e_cf, e_stc, e_rep; int e_sel;
    // Observation logs
    int rsp_cyc[8], rsp_data[8], viol_cnt = 0, last_viol_idx = -1, viol_cyc = -1;

    task automatic chk(string tag, longint act, longint exp);
        vec++;
        if (act != exp) begin
            mis++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int agef(int i);
        return (i - m_head + 8) % 8;
    endfunction

    function automatic bit fwd(int l, output int j);
        for (int k = 1; k <= agef(l); k++) begin
            int c = (l - k + 8) % 8;
            if (mv[c] && mst[c] && mav[c] && maddr[c] == maddr[l]) begin
                j = c;
                return 1'b1;
            end
        end
        j = 0;
        return 1'b0;
    endfunction

    function automatic bit ld_ok(int l);
        int j;
        if (fwd(l, j)) return mdv[j];
        return 1'b1;
    endfunction

    // Compute expected outputs for this cycle and compare
    task automatic eval_cmp();
        bit done, hit; int j, e_tail;
        e_tail = (m_head + m_cnt) % 8;
        done = m_cnt > 0 && (mst[m_head] ? (mav[m_head] && mdv[m_head]) : (miss[m_head] && !mrep[m_head]));
        e_cf = commit_valid && done;
        e_stc = e_cf && mst[m_head];
        e_sel = -1; e_rep = 0;
        for (int k = 0; k < 8 && e_sel < 0; k++) begin
            int i = (m_head + k) % 8;
            if (mv[i] && !mst[i] && mrep[i] && ld_ok(i)) begin e_sel = i; e_rep = 1; end
        end
        for (int k = 0; k < 8 && e_sel < 0; k++) begin
            int i = (m_head + k) % 8;
            if (mv[i] && !mst[i] && mav[i] && !miss[i] && ld_ok(i)) e_sel = i;
        end
        if (e_stc) begin e_sel = -1; e_rep = 0; end
        chk("R1 alloc_ready", alloc_ready, m_cnt < 8);
        chk("R1 alloc_idx", alloc_idx, e_tail);
        chk("R4 commit_ready", commit_ready, done);
        chk("R8 mem_en", mem_en, e_stc || e_sel >= 0);
        chk("R4 mem_wr", mem_wr, e_stc);
        if (e_stc) begin
            chk("R4 mem_addr", mem_addr, maddr[m_head]);
            chk("R4 mem_wdata", mem_wdata, mdata[m_head]);
        end
        chk("R3 ld_resp_valid", ld_resp_valid, e_sel >= 0);
        chk("R5 viol_valid", viol_valid, e_rep);
        if (e_sel >= 0) begin
            hit = fwd(e_sel, j);
            chk("R3 mem_addr", mem_addr, maddr[e_sel]);
            chk("R8 ld_resp_idx", ld_resp_idx, e_sel);
            chk("R3 ld_resp_tag", ld_resp_tag, mtag[e_sel]);
            chk("R7 ld_resp_data", ld_resp_data, hit ? mdata[j] : mm[maddr[e_sel] & 255]);
            if (e_rep) chk("R5 viol_idx", viol_idx, e_sel);
        end
        if (ld_resp_valid) begin rsp_cyc[ld_resp_idx] = cycno; rsp_data[ld_resp_idx] = ld_resp_data; end
        if (viol_valid) begin viol_cnt++; last_viol_idx = viol_idx; viol_cyc = cycno; end
    endtask

    // Advance the model by one clock with the inputs just sampled
    task automatic update();
        bit nrep[8]; int tail;
        tail = (m_head + m_cnt) % 8;
        for (int s = 0; s < 8; s++) begin
            if (mv[s] && mst[s] && mpend[s]) begin
                int na = (mbase[s] + moff[s]) & 16'hFFFF;
                for (int l = 0; l < 8; l++)
                    if (mv[l] && !mst[l] && mav[l] && (miss[l] || l == e_sel)
                        && agef(l) > agef(s) && maddr[l] == na) nrep[l] = 1;
            end
        end
        for (int i = 0; i < 8; i++)
            if (mpend[i]) begin maddr[i] = (mbase[i] + moff[i]) & 16'hFFFF; mav[i] = 1; mpend[i] = 0; end
        if (e_sel >= 0) begin miss[e_sel] = 1; mrep[e_sel] = 0; end
        for (int i = 0; i < 8; i++) if (nrep[i]) mrep[i] = 1;
        if (opnd_valid) begin mbase[opnd_idx] = opnd_base; mpend[opnd_idx] = 1; end
        if (sdat_valid) begin mdata[sdat_idx] = sdat_value; mdv[sdat_idx] = 1; end
        if (alloc_valid && m_cnt < 8) begin
            mv[tail] = 1; mst[tail] = alloc_is_store; mtag[tail] = alloc_tag; moff[tail] = alloc_offset;
            mpend[tail] = 0; mav[tail] = 0; mdv[tail] = 0; miss[tail] = 0; mrep[tail] = 0;
            m_cnt++;
        end
        if (e_stc) mm[maddr[m_head] & 255] = mdata[m_head];
        if (e_cf) begin mv[m_head] = 0; m_head = (m_head + 1) % 8; m_cnt--; end
    endtask

    // One clock: compare, clock edge, model step, clear inputs
    task automatic cyc();
        #1 eval_cmp();
        @(posedge clk);
        #1 update();
        @(negedge clk);
        cycno++;
        alloc_valid = 0; opnd_valid = 0; sdat_valid = 0; commit_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic alloc(bit st, int off, output int idx);
        idx = (m_head + m_cnt) % 8;
        alloc_valid = 1; alloc_is_store = st; alloc_tag = 6'(idx + 8 * st + 16); alloc_offset = 16'(off);
        cyc();
    endtask

    task automatic ev_addr(int idx, int base, output int c);
        c = cycno;
        opnd_valid = 1; opnd_idx = 3'(idx); opnd_base = 16'(base);
        cyc();
    endtask

    task automatic ev_data(int idx, int val);
        sdat_valid = 1; sdat_idx = 3'(idx); sdat_value = 32'(val);
        cyc();
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && m_cnt > 0; i++) begin commit_valid = 1; cyc(); end
        idle(1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    endtask

    initial begin
        #800000;
        mis++;
        $display("FAIL watchdog expired act=%0d exp=done", cycno);
        summary();
        $finish;
    end

    initial begin
        int s, l, l2, s2, a, b, n, c, d, tmp;
        for (int i = 0; i < 256; i++) begin mem[i] = 32'h1000_0000 + i; mm[i] = 32'h1000_0000 + i; end
        @(negedge clk); @(negedge clk);
        // R9: reset state
        chk("R9 alloc_ready", alloc_ready, 1);
        chk("R9 commit_ready", commit_ready, 0);
        chk("R9 mem_en", mem_en, 0);
        chk("R9 ld_resp_valid", ld_resp_valid, 0);
        chk("R9 viol_valid", viol_valid, 0);
        rst_n = 1;
        idle(2);

        // R2 R3 R6: load passes an unresolved store with a different address
        alloc(1, 0, s); alloc(0, 4, l);
        viol_cnt = 0;
        ev_addr(l, 16'h10, c); idle(2);
        chk("R2 R3 issue cycle", rsp_cyc[l], c + 2);
        chk("R3 load value", rsp_data[l], 32'h1000_0014);
        ev_addr(s, 16'h30, tmp); ev_data(s, 32'hDEAD); idle(3);
        chk("R6 no replay", viol_cnt, 0);
        chk("R4 no early write", mem[8'h30], 32'h1000_0030);
        drain();
        chk("R4 write at commit", mem[8'h30], 32'hDEAD);

        // R5 R7: late store address, replay waits for data
        alloc(1, 0, s); alloc(0, 0, l);
        viol_cnt = 0;
        ev_addr(l, 16'h40, tmp); idle(2);
        ev_addr(s, 16'h40, tmp); idle(3);
        chk("R5 replay waits for data", viol_cnt, 0);
        ev_data(s, 32'h1234); idle(2);
        chk("R5 one replay", viol_cnt, 1);
        chk("R5 viol idx", last_viol_idx, l);
        chk("R7 replay data", rsp_data[l], 32'h1234);
        drain();

        // R5: replay in the cycle after the address forms
        alloc(1, 0, s2); alloc(0, 0, l2);
        ev_data(s2, 32'h55);
        ev_addr(l2, 16'h50, tmp); idle(2);
        viol_cnt = 0;
        ev_addr(s2, 16'h50, c); idle(3);
        chk("R5 replay cycle", viol_cyc, c + 2);
        chk("R5 replay count", viol_cnt, 1);
        drain();

        // R10: known matching stores, youngest supplies the data
        alloc(1, 0, a); alloc(1, 0, b); alloc(0, 0, l);
        ev_data(a, 32'hA); ev_data(b, 32'hB);
        ev_addr(a, 16'h60, tmp); ev_addr(b, 16'h60, tmp); idle(2);
        viol_cnt = 0;
        ev_addr(l, 16'h60, tmp); idle(3);
        chk("R10 forward youngest", rsp_data[l], 32'hB);
        chk("R10 no replay", viol_cnt, 0);
        drain();

        // R7: two unresolved stores resolve oldest first, two replays
        alloc(1, 0, c); alloc(1, 0, d); alloc(0, 0, n);
        ev_data(c, 32'hC); ev_data(d, 32'hD);
        ev_addr(n, 16'h70, tmp); idle(2);
        viol_cnt = 0;
        ev_addr(c, 16'h70, tmp); idle(3);
        chk("R7 first replay data", rsp_data[n], 32'hC);
        ev_addr(d, 16'h70, tmp); idle(3);
        chk("R7 youngest store data", rsp_data[n], 32'hD);
        chk("R7 replay count", viol_cnt, 2);
        drain();

        // R1: fill all entries, refused allocation, free one
        for (int i = 0; i < 8; i++) alloc(0, i, tmp);
        chk("R1 full", alloc_ready, 0);
        alloc(0, 0, tmp);
        for (int i = 0; i < 8; i++) ev_addr((m_head + i) % 8, 16'h80, tmp);
        idle(4);
        commit_valid = 1; cyc();
        chk("R1 space after commit", alloc_ready, 1);
        drain();

        // R8: store commit pre-empts a ready load
        alloc(1, 0, s); alloc(0, 0, l);
        ev_data(s, 32'h99); ev_addr(s, 16'h88, tmp); idle(2);
        ev_addr(l, 16'h90, c); idle(1);
        commit_valid = 1; cyc();
        idle(2);
        chk("R8 load after commit", rsp_cyc[l], c + 3);
        chk("R4 committed value", mem[8'h88], 32'h99);
        drain();

        summary();
        $finish;
    end
endmodule